// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Sequencer

This block sequences a single DMA channel. It does not move any data itself. It controls a separate data mover through a two-signal handshake: a start pulse, and a segment-done pulse returned by the mover. For each segment, the mover reads the segment's PCI-side address, local-side address, byte count and direction from the sequencer's working registers.

The channel runs in one of two modes:

- **Single-block mode.** Software loads the four working registers through a small write port, then starts the channel. The sequencer runs exactly one segment.
- **Chained mode.** The pointer register names the first descriptor in memory. The sequencer reads each four-word descriptor through a 32-bit memory read port, runs the segment it describes, and follows its next pointer until a descriptor marks end of chain.

Software drives the channel through a command/status byte. Writing it can enable the channel, start a transfer, abort a transfer or clear the interrupt. Reading it returns the enable bit and a done flag.

The block raises one sticky interrupt, which goes to either the local-side line or the PCI-side line. A finished chain raises it when the done interrupt is enabled. A segment whose pointer word requests a terminal-count interrupt also raises it.

Top module: `sg_dma_seq`

## Requirements
- R1: After reset the status byte reads 0x10 (done set, enable clear), and `mrd_req`, `mv_start`, `irq_local` and `irq_pci` are low.
- R2: Status byte layout: bit 0 returns the last written enable value, bit 4 is the done flag, and bits 1, 2, 3, 5, 6 and 7 always read 0.
- R3: A status write starts the channel only if the written byte has both bit 0 (enable) and bit 1 (start) set. Any other write causes no mover start, no memory read, and leaves done at 1.
- R4: In single-block mode (`cfg_chain`=0), a start produces exactly one one-cycle `mv_start` and no memory reads. At that moment:
  - the mover sees the loaded PCI address and local address;
  - the count is the low 23 bits of the written count;
  - `mv_to_pci` equals pointer bit 3.
- R5: When `mv_done` arrives, the sequencer updates its working registers:
  - the PCI address advances by the count;
  - the local address also advances by the count, unless `cfg_hold_local` is set, in which case it stays unchanged.

  In single-block mode, the done flag returns to 1 in the same edge.
- R6: With `cfg_clr_count` set, the count register reads 0 after its segment completes. Otherwise it keeps the segment's count.
- R7: In chained mode, each descriptor is fetched with four reads:
  - the addresses are the pointer with bits 3:0 forced to 0, then +4, +8 and +12;
  - `mrd_space` equals pointer bit 0;
  - the words are taken in this order: PCI address, local address, byte count, next pointer.

  `mv_start` rises only after the fourth word has been taken.
- R8: After each segment in chained mode, the next pointer's bit 1 decides what happens:
  - if it is clear, the sequencer fetches the descriptor that pointer names;
  - if it is set, the chain ends and the done flag returns to 1.
- R9: A completed segment whose pointer bit 2 is set raises the interrupt.
- R10: With `cfg_done_ie` set, finishing the channel raises the interrupt. It appears on `irq_pci` when `cfg_irq_pci`=1 and on `irq_local` otherwise, never on both.
- R11: The interrupt stays active until a status write with bit 3 set, which clears it.
- R12: An abort (status write with bit 2 set) accepted while the channel is active has these effects:
  - the current mover segment is allowed to finish;
  - no further descriptor is read;
  - the done flag returns to 1 once that segment's `mv_done` arrives.
- R13: An abort while the channel is idle has no effect: done stays 1, no mover start or read follows, and the working registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the status/command byte |
| csr_wdata | input | 8 | Command byte: bit0 enable, bit1 start, bit2 abort, bit3 clear interrupt |
| csr_rdata | output | 8 | Status byte: bit0 enable, bit4 done |
| cfg_chain | input | 1 | 1 = chained descriptor mode |
| cfg_done_ie | input | 1 | Raise interrupt on channel completion |
| cfg_irq_pci | input | 1 | Route interrupt to PCI side (1) or local side (0) |
| cfg_clr_count | input | 1 | Clear count after each segment |
| cfg_hold_local | input | 1 | Keep local address constant |
| reg_wr | input | 1 | Working register write strobe (idle only) |
| reg_sel | input | 2 | 0 PCI addr, 1 local addr, 2 count, 3 pointer |
| reg_wdata | input | 32 | Working register write data |
| cur_pci_addr | output | 32 | PCI-side address register |
| cur_loc_addr | output | 32 | Local-side address register |
| cur_count | output | 23 | Byte count register |
| cur_ptr | output | 32 | Next pointer register with flags |
| mrd_req | output | 1 | Descriptor read request, held until acknowledged |
| mrd_addr | output | 32 | Descriptor read address |
| mrd_space | output | 1 | 1 = read from PCI space, 0 = local space |
| mrd_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mrd_data | input | 32 | Read data |
| mv_start | output | 1 | One-cycle segment start to the mover |
| mv_to_pci | output | 1 | Segment direction: 1 local-to-PCI |
| mv_hold_local | output | 1 | Mover must not increment the local address |
| mv_done | input | 1 | Mover reports the segment finished |
| irq_local | output | 1 | Interrupt request, local side |
| irq_pci | output | 1 | Interrupt request, PCI side |

## Verification
The bench targets these corner cases, and what a faulty design would show:

- **Count masking.** A count word with garbage above bit 22 is used. A design that failed to mask would hand the mover a huge count or advance the addresses wrongly.
- **Address wrap.** A PCI address at the top of the 32-bit space is used, so advancing it must wrap to a small value.
- **Space and flags.** The memory-space bit is changed between descriptors to show it is taken from the pointer that names each descriptor, not carried over from the first one. The fetch log also shows that flag bits never leak into read addresses.
- **Abort mid-segment.** A design that kept following the chain would show more than four reads. One that set done early would show done before `mv_done`.
- **Start without enable, abort while idle.** Either one yielding a mover start or a register change marks a decode error.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_KICK  = 2'd2,
        ST_MOVE  = 2'd3
    } sgd_state_e;

    // descriptor geometry
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned DESC_ALIGN = 4;   // address bits forced to zero

    // word order inside a descriptor (also the register-select code)
    localparam logic [1:0] W_PCI  = 2'd0;
    localparam logic [1:0] W_LOC  = 2'd1;
    localparam logic [1:0] W_CNT  = 2'd2;
    localparam logic [1:0] W_NEXT = 2'd3;

    // flag bits in the pointer word
    localparam int unsigned PF_SPACE = 0;
    localparam int unsigned PF_EOC   = 1;
    localparam int unsigned PF_TC    = 2;
    localparam int unsigned PF_DIR   = 3;

    // command/status byte bits
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_GO    = 1;
    localparam int unsigned CB_STOP  = 2;
    localparam int unsigned CB_ACK   = 3;
    localparam int unsigned CB_DONE  = 4;

endpackage

// File: rtl/sgd_desc_fetch.sv
module sgd_desc_fetch
    import sgd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              space_in,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    output logic              mrd_space,
    input  logic              mrd_ack,
    output logic              cap_en,
    output logic [1:0]        cap_idx,
    output logic              cap_last
);

    localparam int unsigned IDX_W    = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic              space;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (go) begin
            f_d.busy  = 1'b1;
            f_d.idx   = '0;
            f_d.base  = {base_in[ADDR_W-1:DESC_ALIGN], {DESC_ALIGN{1'b0}}};
            f_d.space = space_in;
        end else if (f_q.busy && mrd_ack) begin
            if (f_q.idx == LAST_IDX) begin
                f_d.busy = 1'b0;
            end else begin
                f_d.idx = f_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mrd_req   = f_q.busy;
    assign mrd_addr  = f_q.base + (ADDR_W'(f_q.idx) << 2);
    assign mrd_space = f_q.space;
    assign cap_en    = f_q.busy && mrd_ack;
    assign cap_idx   = 2'(f_q.idx);
    assign cap_last  = cap_en && (f_q.idx == LAST_IDX);

endmodule

// File: rtl/sgd_advance.sv
module sgd_advance #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 23
) (
    input  logic [ADDR_W-1:0] pci_in,
    input  logic [ADDR_W-1:0] loc_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              hold_local,
    input  logic              clr_count,
    output logic [ADDR_W-1:0] pci_out,
    output logic [ADDR_W-1:0] loc_out,
    output logic [CNT_W-1:0]  cnt_out
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step    = ADDR_W'(cnt_in);
        pci_out = pci_in + step;
        loc_out = hold_local ? loc_in : (loc_in + step);
        cnt_out = clr_count ? '0 : cnt_in;
    end

endmodule

// File: rtl/sgd_irq.sv
module sgd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic to_pci,
    output logic irq_local,
    output logic irq_pci
);

    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (set) begin
            act_d = 1'b1;
        end else if (clr) begin
            act_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_d;
        end
    end

    assign irq_local = act_q && !to_pci;
    assign irq_pci   = act_q && to_pci;

endmodule

// File: rtl/sg_dma_seq.sv
module sg_dma_seq
    import sgd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              cfg_chain,
    input  logic              cfg_done_ie,
    input  logic              cfg_irq_pci,
    input  logic              cfg_clr_count,
    input  logic              cfg_hold_local,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] cur_pci_addr,
    output logic [ADDR_W-1:0] cur_loc_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    output logic              mrd_space,
    input  logic              mrd_ack,
    input  logic [ADDR_W-1:0] mrd_data,
    output logic              mv_start,
    output logic              mv_to_pci,
    output logic              mv_hold_local,
    input  logic              mv_done,
    output logic              irq_local,
    output logic              irq_pci
);

    typedef struct packed {
        sgd_state_e        state;
        logic              en;
        logic              done;
        logic              pend;
        logic [ADDR_W-1:0] pci;
        logic [ADDR_W-1:0] loc;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic              fetch_go;
    logic              cap_en;
    logic [1:0]        cap_idx;
    logic              cap_last;
    logic [ADDR_W-1:0] adv_pci, adv_loc;
    logic [CNT_W-1:0]  adv_cnt;
    logic              irq_set;
    logic              wr_go, wr_stop, wr_ack;
    logic              load_en;
    logic [1:0]        load_idx;
    logic [ADDR_W-1:0] load_val;
    logic              finish;
    logic              tc_hit;

    sgd_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fetch_go),
        .base_in  (s_q.ptr),
        .space_in (s_q.ptr[PF_SPACE]),
        .mrd_req  (mrd_req),
        .mrd_addr (mrd_addr),
        .mrd_space(mrd_space),
        .mrd_ack  (mrd_ack),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_last (cap_last)
    );

    sgd_advance #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_adv (
        .pci_in    (s_q.pci),
        .loc_in    (s_q.loc),
        .cnt_in    (s_q.cnt),
        .hold_local(cfg_hold_local),
        .clr_count (cfg_clr_count),
        .pci_out   (adv_pci),
        .loc_out   (adv_loc),
        .cnt_out   (adv_cnt)
    );

    sgd_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (irq_set),
        .clr      (wr_ack),
        .to_pci   (cfg_irq_pci),
        .irq_local(irq_local),
        .irq_pci  (irq_pci)
    );

    assign wr_go   = csr_wr && csr_wdata[CB_EN] && csr_wdata[CB_GO];
    assign wr_stop = csr_wr && csr_wdata[CB_STOP];
    assign wr_ack  = csr_wr && csr_wdata[CB_ACK];

    // register loads share one path: software writes while idle, fetched words
    assign load_en  = cap_en || (reg_wr && (s_q.state == ST_IDLE));
    assign load_idx = cap_en ? cap_idx : reg_sel;
    assign load_val = cap_en ? mrd_data : reg_wdata;

    always_comb begin
        s_d      = s_q;
        fetch_go = 1'b0;
        finish   = 1'b0;
        tc_hit   = 1'b0;

        if (csr_wr) begin
            s_d.en = csr_wdata[CB_EN];
        end

        if (load_en) begin
            case (load_idx)
                W_PCI:   s_d.pci = load_val;
                W_LOC:   s_d.loc = load_val;
                W_CNT:   s_d.cnt = load_val[CNT_W-1:0];
                default: s_d.ptr = load_val;
            endcase
        end

        case (s_q.state)
            ST_IDLE: begin
                if (wr_go) begin
                    s_d.done = 1'b0;
                    s_d.pend = 1'b0;
                    if (cfg_chain) begin
                        fetch_go  = 1'b1;
                        s_d.state = ST_FETCH;
                    end else begin
                        s_d.state = ST_KICK;
                    end
                end
            end
            ST_FETCH: begin
                if (wr_stop) begin
                    s_d.pend = 1'b1;
                end
                if (cap_last) begin
                    if (s_q.pend || wr_stop) begin
                        finish = 1'b1;
                    end else begin
                        s_d.state = ST_KICK;
                    end
                end
            end
            ST_KICK: begin
                if (wr_stop) begin
                    s_d.pend = 1'b1;
                end
                s_d.state = ST_MOVE;
            end
            default: begin
                if (wr_stop) begin
                    s_d.pend = 1'b1;
                end
                if (mv_done) begin
                    s_d.pci = adv_pci;
                    s_d.loc = adv_loc;
                    s_d.cnt = adv_cnt;
                    tc_hit  = s_q.ptr[PF_TC];
                    if (!cfg_chain || s_q.ptr[PF_EOC] || s_q.pend || wr_stop) begin
                        finish = 1'b1;
                    end else begin
                        fetch_go  = 1'b1;
                        s_d.state = ST_FETCH;
                    end
                end
            end
        endcase

        if (finish) begin
            s_d.state = ST_IDLE;
            s_d.done  = 1'b1;
        end
    end

    assign irq_set = tc_hit || (finish && cfg_done_ie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, en: 1'b0, done: 1'b1, pend: 1'b0,
                     pci: '0, loc: '0, ptr: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        csr_rdata          = 8'h00;
        csr_rdata[CB_EN]   = s_q.en;
        csr_rdata[CB_DONE] = s_q.done;
    end

    assign cur_pci_addr  = s_q.pci;
    assign cur_loc_addr  = s_q.loc;
    assign cur_count     = s_q.cnt;
    assign cur_ptr       = s_q.ptr;
    assign mv_start      = (s_q.state == ST_KICK);
    assign mv_to_pci     = s_q.ptr[PF_DIR];
    assign mv_hold_local = cfg_hold_local;

endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [7:0]        csr_wdata,
    input logic [7:0]        csr_rdata,
    input logic              mrd_req,
    input logic              mrd_ack,
    input logic [ADDR_W-1:0] mrd_addr,
    input logic              mv_start,
    input logic              irq_local,
    input logic              irq_pci
);

    // R7: an unacknowledged read holds its request and address
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && !mrd_ack |=> mrd_req && $stable(mrd_addr));

    // R7: fetch addresses are word aligned
    p_addr_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req |-> mrd_addr[1:0] == 2'b00);

    // R4: mover start lasts one cycle
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R5: done flag low while the channel reads or starts a segment
    p_busy_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_start || mrd_req) |-> !csr_rdata[4]);

    // R11: interrupt stays until cleared
    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_local || irq_pci) && !(csr_wr && csr_wdata[3]) |=> (irq_local || irq_pci));

    // R10: never both interrupt lines
    p_irq_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_local && irq_pci));

    // R3: write without start while idle starts nothing
    p_no_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !(csr_wdata[0] && csr_wdata[1]) && csr_rdata[4] |=> !mv_start && !mrd_req);

endmodule

bind sg_dma_seq sgd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_wr   (csr_wr),
    .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .mrd_req  (mrd_req),
    .mrd_ack  (mrd_ack),
    .mrd_addr (mrd_addr),
    .mv_start (mv_start),
    .irq_local(irq_local),
    .irq_pci  (irq_pci)
);

// File: tb/sim_sg_dma_seq.sv
`timescale 1ns/1ps
module sim_sg_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        cfg_chain = 1'b0, cfg_done_ie = 1'b0, cfg_irq_pci = 1'b0;
    logic        cfg_clr_count = 1'b0, cfg_hold_local = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cur_pci_addr, cur_loc_addr, cur_ptr;
    logic [22:0] cur_count;
    logic        mrd_req, mrd_space, mrd_ack;
    logic [31:0] mrd_addr, mrd_data;
    logic        mv_start, mv_to_pci, mv_hold_local;
    logic        mv_done = 1'b0;
    logic        irq_local, irq_pci;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:15];
    assign mrd_ack  = mrd_req;
    assign mrd_data = mem[mrd_addr[5:2]];

    int          nreads = 0;
    int          nstarts = 0;
    logic [31:0] log_addr [0:31];
    logic        log_space [0:31];

    always #4 clk = ~clk;

    sg_dma_seq u0 (.*);

    always @(posedge clk) begin
        if (rst_n && mrd_req && mrd_ack) begin
            if (nreads < 32) begin
                log_addr[nreads]  = mrd_addr;
                log_space[nreads] = mrd_space;
            end
            nreads = nreads + 1;
        end
        if (rst_n && mv_start) nstarts = nstarts + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [7:0] v);
        @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
        @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // wait for a mover start, report what was seen, then complete the segment
    task automatic serve(output logic [31:0] p, output logic [31:0] l,
                         output logic [22:0] c, output logic d, output int reads_at);
        int t = 0;
        while (!mv_start && t < 200) begin @(negedge clk); t++; end
        p = cur_pci_addr; l = cur_loc_addr; c = cur_count; d = mv_to_pci;
        reads_at = nreads;
        repeat (2) @(negedge clk);
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!csr_rdata[4] && t < 200) begin @(negedge clk); t++; end
    endtask

    // pci, loc, count word, flags, hold, clr, done_ie, to_pci
    localparam logic [103:0] VEC [0:3] = '{
        {32'h1000_0000, 32'h0000_8000, 32'h0000_0100, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h2000_0004, 32'h0000_9000, 32'hFF80_0040, 4'h8, 1'b1, 1'b1, 1'b0, 1'b1},
        {32'h3000_0000, 32'h0000_A000, 32'h007F_FFFF, 4'h4, 1'b0, 1'b0, 1'b0, 1'b1},
        {32'hFFFF_FFF0, 32'h0000_0010, 32'h0000_0020, 4'hC, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] sp, sl; logic [22:0] sc; logic sd; int ra;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(csr_rdata == 8'h10, "R1 status", {24'h0, csr_rdata}, 32'h10);
        chk(!mrd_req && !mv_start && !irq_local && !irq_pci, "R1 outputs",
            {28'h0, mrd_req, mv_start, irq_local, irq_pci}, 32'h0);

        // R2 enable readback, write-only bits read zero
        csr_write(8'h01);
        chk(csr_rdata == 8'h11, "R2 enable readback", {24'h0, csr_rdata}, 32'h11);

        // R3 start without enable is ignored
        csr_write(8'h02);
        repeat (4) @(negedge clk);
        chk(nstarts == 0 && nreads == 0 && csr_rdata == 8'h10, "R3 start no enable",
            {nstarts[15:0], 8'h0, csr_rdata}, 32'h10);

        // single-block vectors: R4 R5 R6 R9 R10 R11
        for (int v = 0; v < 4; v++) begin
            logic [31:0] p, l, cw; logic [3:0] fl; logic h, cl, die, tp;
            logic [22:0] c23; logic exp_irq; int s0;
            {p, l, cw, fl, h, cl, die, tp} = VEC[v];
            c23 = cw[22:0];
            cfg_chain = 1'b0; cfg_hold_local = h; cfg_clr_count = cl;
            cfg_done_ie = die; cfg_irq_pci = tp;
            reg_write(2'd0, p); reg_write(2'd1, l); reg_write(2'd2, cw); reg_write(2'd3, {28'h0, fl});
            s0 = nstarts;
            csr_write(8'h03);
            serve(sp, sl, sc, sd, ra);
            chk(sp == p && sl == l, "R4 mover addresses", sp, p);
            chk(sc == c23, "R4 count masked", {9'h0, sc}, {9'h0, c23});
            chk(sd == fl[3], "R4 direction", {31'h0, sd}, {31'h0, fl[3]});
            wait_done();
            chk(nstarts == s0 + 1 && nreads == 0, "R4 one start no reads", nstarts, s0 + 1);
            chk(cur_pci_addr == p + {9'h0, c23}, "R5 pci advance", cur_pci_addr, p + {9'h0, c23});
            chk(cur_loc_addr == (h ? l : l + {9'h0, c23}), "R5 local advance",
                cur_loc_addr, h ? l : l + {9'h0, c23});
            chk(cur_count == (cl ? 23'h0 : c23), "R6 count after segment",
                {9'h0, cur_count}, {9'h0, (cl ? 23'h0 : c23)});
            exp_irq = fl[2] | die;
            chk(irq_pci == (exp_irq & tp) && irq_local == (exp_irq & !tp), "R9 R10 interrupt",
                {30'h0, irq_pci, irq_local}, {30'h0, exp_irq & tp, exp_irq & !tp});
            csr_write(8'h08);
            chk(!irq_pci && !irq_local, "R11 clear interrupt", {30'h0, irq_pci, irq_local}, 32'h0);
        end

        // R13 abort while idle
        begin
            logic [31:0] p0; int s0;
            p0 = cur_pci_addr; s0 = nstarts;
            csr_write(8'h05);
            repeat (4) @(negedge clk);
            chk(csr_rdata[4] && nstarts == s0 && nreads == 0 && cur_pci_addr == p0,
                "R13 idle abort", cur_pci_addr, p0);
        end

        // chained run: R7 R8 R9
        mem[0] = 32'h0000_1000; mem[1] = 32'h0000_2000; mem[2]  = 32'h0000_0040; mem[3]  = 32'h0000_0014;
        mem[4] = 32'h0000_3000; mem[5] = 32'h0000_4000; mem[6]  = 32'h7F00_0020; mem[7]  = 32'h0000_0028;
        mem[8] = 32'h0000_5000; mem[9] = 32'h0000_6000; mem[10] = 32'h0000_0080; mem[11] = 32'h0000_0032;
        cfg_chain = 1'b1; cfg_hold_local = 1'b0; cfg_clr_count = 1'b0; cfg_done_ie = 1'b0; cfg_irq_pci = 1'b0;
        reg_write(2'd3, 32'h0000_000D);
        csr_write(8'h03);
        serve(sp, sl, sc, sd, ra);
        chk(ra == 4, "R7 start after fourth word", ra, 4);
        chk(sp == 32'h1000 && sl == 32'h2000 && sc == 23'h40 && !sd, "R7 seg0 fields", sp, 32'h1000);
        serve(sp, sl, sc, sd, ra);
        chk(ra == 8 && sp == 32'h3000 && sl == 32'h4000 && sc == 23'h20 && sd, "R8 seg1 fields", sp, 32'h3000);
        serve(sp, sl, sc, sd, ra);
        chk(ra == 12 && sp == 32'h5000 && sc == 23'h80 && !sd, "R8 seg2 fields", sp, 32'h5000);
        wait_done();
        repeat (3) @(negedge clk);
        chk(nreads == 12 && csr_rdata[4], "R8 end of chain", nreads, 12);
        for (int k = 0; k < 12; k++) begin
            logic [31:0] ea; logic es;
            ea = 32'((k / 4) * 16 + (k % 4) * 4);
            es = (k < 4);
            chk(log_addr[k] == ea && log_space[k] == es, "R7 fetch address/space", log_addr[k], ea);
        end
        chk(cur_pci_addr == 32'h5080 && cur_ptr == 32'h32, "R8 final regs", cur_pci_addr, 32'h5080);
        chk(irq_local && !irq_pci, "R9 terminal count irq", {30'h0, irq_pci, irq_local}, 32'h1);
        csr_write(8'h08);

        // R12 abort mid-segment
        nreads = 0;
        begin
            int s0; int t;
            s0 = nstarts;
            reg_write(2'd3, 32'h0000_0000);
            csr_write(8'h03);
            t = 0;
            while (!mv_start && t < 200) begin @(negedge clk); t++; end
            @(negedge clk);
            csr_wr = 1'b1; csr_wdata = 8'h05;
            @(negedge clk);
            csr_wr = 1'b0; csr_wdata = '0;
            chk(!csr_rdata[4], "R12 done waits for mover", {24'h0, csr_rdata}, 32'h0);
            mv_done = 1'b1;
            @(negedge clk);
            mv_done = 1'b0;
            repeat (6) @(negedge clk);
            chk(csr_rdata[4] && nreads == 4 && nstarts == s0 + 1, "R12 abort stops chain", nreads, 4);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule